// File: doc/BRIEF.md
# Entropy Sampling and Debias Pipeline

This block turns a single raw entropy bit, produced by free-running oscillators outside the block, into 32-bit random words. The raw bit is sampled on a clock enable derived from the system clock. A programmable number of start-up samples is thrown away. Each later group of samples is folded into one reduced bit by XOR. The reduced bits can optionally pass through a pairwise bias corrector. Every bit that survives is shifted into the result register.

Software programs one 32-bit control word and raises the enable. It waits for the initialized cause and then collects a word each time the ready flag rises. The read strobe takes the word and starts the count for the next one. Two detect strobes from external health tests can each be set to halt the generator. A halted generator stays halted until the enable is dropped and raised again.

The raw bit is taken to be synchronous to the system clock already. The sample divider is a clock enable, not a derived clock.

Top module: `trng_debias_core`

## Requirements
- R1: After reset, `result_word` is 0, `word_ready` is 0 and `init_done` is 0.
- R2: With sample divider D in control bits 7:0, a sample of `raw_bit` is taken once every D+1 enabled clocks. The first sample falls on the (D+1)-th clock after `gen_en` rises.
- R3: With drop count I in control bits 23:16, the first I+1 samples after enabling are discarded. `init_done` rises on the clock that takes the (I+1)-th sample. It reads 0 whenever the generator is not running.
- R4: With reduction divider R in control bits 15:8, each reduced bit is the XOR of R+1 consecutive kept samples, in non-overlapping windows.
- R5: With control bit 24 at 0, every reduced bit is accepted. Accepted bits enter `result_word` at bit 0, and older bits move toward bit 31.
- R6: With control bit 24 at 1, reduced bits are paired without overlap as (older, newer). Pair 01 accepts a 0 and pair 10 accepts a 1. Pairs 00 and 11 accept nothing, so a constant input never changes the result.
- R7: `word_ready` is 1 once 32 bits have been accepted since the last read or the last enable. The `word_rd` strobe clears it. A bit accepted in the same clock as the read counts toward the next word.
- R8: When control bit 28 is 1, an `ap_detect` pulse halts the generator. The result then stays frozen, and `word_ready` and `init_done` read 0 until `gen_en` is dropped.
- R9: When control bit 29 is 1, an `rc_detect` pulse halts the generator in the same way as R8.
- R10: A detect strobe whose stop bit is 0 has no effect on the produced words.
- R11: Dropping `gen_en` clears the drop, reduction and corrector-pair state and the partial word count. The next enable runs the discard phase again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_word | input | 32 | Divider, drop, corrector and stop settings |
| gen_en | input | 1 | Generator enable |
| raw_bit | input | 1 | Synchronized raw oscillator bit |
| ap_detect | input | 1 | Adaptive-proportion detect strobe |
| rc_detect | input | 1 | Repetition-count detect strobe |
| word_rd | input | 1 | Word read strobe |
| result_word | output | 32 | Shift register of accepted bits |
| word_ready | output | 1 | A full fresh word is available |
| init_done | output | 1 | Discard phase finished (interrupt cause) |

## Verification
The raw bit is driven from a pseudo-random sequence that changes once per sample window. Every word therefore depends on the exact sample instants: a divider that is off by one reads a neighbouring value and breaks the match.

The settings swept are:
- a sample divider of 0, 1, 2 and 255;
- a reduction divider of 0, 1, 2 and 255;
- several drop counts;
- the corrector both on and off.

Between them these separate the off-by-one encoding of each field. They also separate XOR folding from plain selection, and oldest-bit from newest-bit corrector output.

A constant input with the corrector on must never change the result. Detect pulses are sent both with their stop bits clear and with them set, which tells an ignored strobe from a halting one. Runs that follow each other leave a partial word behind, which shows whether disabling clears the bit count.

// File: rtl/trng_debias_core.sv
`timescale 1ns/1ps
module trng_debias_core #(
  parameter int RES_W = 32,
  parameter int FLD_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      ctrl_word,
  input  logic             gen_en,
  input  logic             raw_bit,
  input  logic             ap_detect,
  input  logic             rc_detect,
  input  logic             word_rd,
  output logic [RES_W-1:0] result_word,
  output logic             word_ready,
  output logic             init_done
);
  localparam int CNT_W    = $clog2(RES_W + 1);
  localparam int SDIV_LSB = 0;
  localparam int RDIV_LSB = 8;
  localparam int IDLY_LSB = 16;
  localparam int VN_BIT   = 24;
  localparam int SAP_BIT  = 28;
  localparam int SRC_BIT  = 29;
  localparam logic [CNT_W-1:0] FULL = CNT_W'(RES_W);

  logic [FLD_W-1:0] smp_div, red_div, init_dly;
  logic vn_en, stop_ap, stop_rc;
  logic unused_ctrl;

  assign smp_div  = ctrl_word[SDIV_LSB +: FLD_W];
  assign red_div  = ctrl_word[RDIV_LSB +: FLD_W];
  assign init_dly = ctrl_word[IDLY_LSB +: FLD_W];
  assign vn_en    = ctrl_word[VN_BIT];
  assign stop_ap  = ctrl_word[SAP_BIT];
  assign stop_rc  = ctrl_word[SRC_BIT];
  assign unused_ctrl = ^{ctrl_word[31:30], ctrl_word[27:25]};

  logic             halted;
  logic [FLD_W-1:0] smp_cnt, drop_cnt, red_cnt;
  logic             dropping, red_acc;
  logic             pair_full, pair_old;
  logic [RES_W-1:0] res_q;
  logic [CNT_W-1:0] bit_cnt;
  logic             init_q;

  logic active, stop_now, run, tick, keep, acc_next, red_done, accept, abit, drop_last;

  assign active    = gen_en & ~halted;
  assign stop_now  = active & ((ap_detect & stop_ap) | (rc_detect & stop_rc));
  assign run       = active & ~stop_now;
  assign tick      = run & (smp_cnt == smp_div);
  assign drop_last = tick & dropping & (drop_cnt == init_dly);
  assign keep      = tick & ~dropping;
  assign acc_next  = red_acc ^ raw_bit;
  assign red_done  = keep & (red_cnt == red_div);
  assign accept    = red_done & (~vn_en | (pair_full & (pair_old != acc_next)));
  assign abit      = vn_en ? pair_old : acc_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            halted <= 1'b0;
    else if (!gen_en)      halted <= 1'b0;
    else if (stop_now)     halted <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            smp_cnt <= '0;
    else if (!run || tick) smp_cnt <= '0;
    else                   smp_cnt <= smp_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dropping <= 1'b1;
      drop_cnt <= '0;
      init_q   <= 1'b0;
    end else if (!run) begin
      dropping <= 1'b1;
      drop_cnt <= '0;
      init_q   <= 1'b0;
    end else if (drop_last) begin
      dropping <= 1'b0;
      init_q   <= 1'b1;
    end else if (tick && dropping) begin
      drop_cnt <= drop_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      red_cnt <= '0;
      red_acc <= 1'b0;
    end else if (!run || red_done) begin
      red_cnt <= '0;
      red_acc <= 1'b0;
    end else if (keep) begin
      red_cnt <= red_cnt + 1'b1;
      red_acc <= acc_next;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pair_full <= 1'b0;
      pair_old  <= 1'b0;
    end else if (!run) begin
      pair_full <= 1'b0;
    end else if (red_done && vn_en) begin
      pair_full <= ~pair_full;
      if (!pair_full) pair_old <= acc_next;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      res_q <= '0;
    else if (accept) res_q <= {res_q[RES_W-2:0], abit};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       bit_cnt <= '0;
    else if (!run)                    bit_cnt <= '0;
    else if (word_rd)                 bit_cnt <= accept ? CNT_W'(1) : '0;
    else if (accept && bit_cnt != FULL) bit_cnt <= bit_cnt + 1'b1;
  end

  assign result_word = res_q;
  assign word_ready  = (bit_cnt == FULL);
  assign init_done   = init_q;

  assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= FULL);
  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    word_rd |=> !word_ready);
  assert_init_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_en |=> !init_done);
  assert_init_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done) |-> $past(tick));
  assert_stop_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_now |=> ($stable(result_word) && !word_ready && !init_done));
  assert_halt_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && gen_en) |=> $stable(result_word));
endmodule

// File: tb/trng_debias_core_tb_top.sv
`timescale 1ns/1ps
module trng_debias_core_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ctrl_word = 32'h0003_0000;
  logic        gen_en = 1'b0, raw_bit = 1'b0, ap_detect = 1'b0, rc_detect = 1'b0, word_rd = 1'b0;
  logic [31:0] result_word;
  logic        word_ready, init_done;

  int n_run = 0, n_fail = 0;
  string cur_tag = "R1";
  logic [31:0] exp_q[$];
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;

  trng_debias_core dut_i (
    .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .gen_en(gen_en), .raw_bit(raw_bit),
    .ap_detect(ap_detect), .rc_detect(rc_detect), .word_rd(word_rd),
    .result_word(result_word), .word_ready(word_ready), .init_done(init_done));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic next_bit();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  // monitor: pops the expected word whenever a full word is flagged
  initial begin
    forever begin
      @(negedge clk); #1;
      if (word_ready) begin
        if (exp_q.size() == 0) chk(1'b0, {cur_tag, " unexpected word"}, result_word, 32'h0);
        else begin
          logic [31:0] e;
          e = exp_q.pop_front();
          chk(result_word == e, cur_tag, result_word, e);
        end
        word_rd = 1'b1;
        @(negedge clk); #1;
        word_rd = 1'b0;
      end
    end
  end

  // driver: one raw value per sample window, with a model of the expected words
  task automatic run_stream(input int d, input int r, input int i, input bit vn,
                            input bit [1:0] stp, input int nwords, input string tag);
    int k = 0, words = 0, rc = 0, n = 0;
    logic acc = 1'b0, pf = 1'b0, po = 1'b0, red, s;
    logic [31:0] w = '0;
    cur_tag = tag;
    gen_en = 1'b0;
    @(negedge clk);
    ctrl_word = {2'b00, stp, 3'b000, vn, i[7:0], r[7:0], d[7:0]};
    @(negedge clk);
    chk(init_done == 1'b0, {tag, " R11 init cleared by disable"}, {31'b0, init_done}, 32'h0);
    gen_en = 1'b1;
    while (words < nwords) begin
      if (k == i)     chk(init_done == 1'b0, {tag, " R3 init before last drop"}, {31'b0, init_done}, 32'h0);
      if (k == i + 1) chk(init_done == 1'b1, {tag, " R3 init after drop"}, {31'b0, init_done}, 32'h1);
      s = next_bit();
      raw_bit = s;
      if (k > i) begin
        acc = acc ^ s;
        if (rc == r) begin
          red = acc; acc = 1'b0; rc = 0;
          if (!vn) begin
            w = {w[30:0], red}; n++;
            if (n == 32) begin exp_q.push_back(w); n = 0; words++; end
          end else if (!pf) begin
            pf = 1'b1; po = red;
          end else begin
            pf = 1'b0;
            if (po != red) begin
              w = {w[30:0], po}; n++;
              if (n == 32) begin exp_q.push_back(w); n = 0; words++; end
            end
          end
        end else rc++;
      end
      k++;
      repeat (d + 1) @(negedge clk);
    end
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, {tag, " all words seen"}, exp_q.size(), 32'h0);
    gen_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic stop_test(input bit use_rc, input string tag);
    logic [31:0] snap;
    cur_tag = tag;
    gen_en = 1'b0;
    @(negedge clk);
    ctrl_word = use_rc ? 32'h2000_0000 : 32'h1000_0000;
    @(negedge clk);
    gen_en = 1'b1;
    repeat (10) begin raw_bit = next_bit(); @(negedge clk); end
    if (use_rc) rc_detect = 1'b1; else ap_detect = 1'b1;
    @(negedge clk);
    rc_detect = 1'b0; ap_detect = 1'b0;
    snap = result_word;
    repeat (60) begin raw_bit = next_bit(); @(negedge clk); end
    chk(result_word == snap, {tag, " result frozen"}, result_word, snap);
    chk(word_ready == 1'b0 && init_done == 1'b0, {tag, " flags low when halted"},
        {30'b0, word_ready, init_done}, 32'h0);
    gen_en = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] snap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(result_word == 0 && word_ready == 0 && init_done == 0, "R1 reset state",
        {result_word[29:0], word_ready, init_done}, 32'h0);

    run_stream(0, 0, 3, 1'b0, 2'b00, 3, "R2 R3 R4 R5 R7 default");
    run_stream(2, 1, 0, 1'b0, 2'b00, 2, "R2 R4 R5 R11 div2 red1");
    run_stream(1, 0, 5, 1'b1, 2'b00, 2, "R6 corrector");
    run_stream(0, 2, 1, 1'b1, 2'b00, 1, "R4 R6 red2 corrector");
    run_stream(255, 0, 0, 1'b0, 2'b00, 1, "R2 div255");
    run_stream(0, 255, 2, 1'b0, 2'b00, 1, "R4 red255");

    fork
      run_stream(0, 0, 0, 1'b0, 2'b00, 2, "R10 strobes ignored");
      begin
        repeat (30) @(negedge clk);
        ap_detect = 1'b1; @(negedge clk); ap_detect = 1'b0;
        repeat (10) @(negedge clk);
        rc_detect = 1'b1; @(negedge clk); rc_detect = 1'b0;
      end
    join

    stop_test(1'b0, "R8 adaptive stop");
    stop_test(1'b1, "R9 repetition stop");
    run_stream(0, 0, 1, 1'b0, 2'b11, 1, "R11 restart after stop");

    cur_tag = "R6 constant";
    ctrl_word = 32'h0100_0000;
    @(negedge clk);
    gen_en = 1'b1;
    raw_bit = 1'b1;
    @(negedge clk);
    snap = result_word;
    repeat (200) @(negedge clk);
    chk(result_word == snap && word_ready == 0, "R6 constant input accepts nothing", result_word, snap);
    gen_en = 1'b0;
    repeat (2) @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule